// File: doc/BRIEF.md
# Windowed Watchdog Supervisor with Request-Mode Timeout

This block supervises a host processor through a windowed watchdog that runs only while the device is in Normal mode. Each watchdog period has two halves. The first half is a closed window, and a clear strobe in that half is a violation. The second half is an open window, and a clear strobe there is accepted and starts a new period. A violation, or a period that ends with no clear, raises a processor reset request. The request is held for a fixed number of time-base ticks. The clear strobe comes from a decoder that watches writes to the mode-control bits over SPI. All timing runs on one tick enable that stands in for the analog time base.

The period length comes from a configuration sense input. A sensed external resistor selects the precise base count. A sensed ground connection switches the Normal-mode watchdog off and raises an off flag. When neither is sensed, the block falls back to an internal default count and raises a fault flag. The sense value is captured only while the device is in Reset mode and is held unchanged in every other mode. A 2-bit prescaler code shifts the base count left. The block samples this code when each period starts. In Normal Request mode the window watchdog is idle. A single timeout runs instead, and when it expires the block raises the same reset request.

The FSM has five states: IDLE, CLOSED, OPEN, NREQ and RST.
- From IDLE, the next state follows the mode. Normal mode goes to CLOSED unless the watchdog is off. Normal Request mode goes to NREQ. Any other mode stays in IDLE.
- CLOSED moves to OPEN on the tick that completes half the period. A clear in CLOSED moves to RST.
- OPEN moves to CLOSED on a clear, which restarts the period. OPEN moves to RST on the tick that completes the period.
- NREQ moves to RST on the tick that completes the timeout.
- CLOSED, OPEN and NREQ each take the entry path when the mode no longer matches the state.
- RST takes the entry path after its hold ticks.

Top module: `wdg_window_ctrl`

## Requirements
- R1: The configuration sense input (0 = neither resistor nor ground, 1 = resistor, 2 = ground, 3 = treated like 0) is captured on every clock while mode_i is 0 (Reset). In the modes 1 (Normal Request), 2 (Normal) and 3 (Sleep), the flags it drives do not change.
- R2: A ground code sets wd_off_o. While wd_off_o is high, the Normal-mode watchdog never raises a reset request, whatever the clears or ticks.
- R3: A code of 0 or 3 sets tb_fault_o and selects a base of DEF_TICKS. wd_off_o and tb_fault_o are never high together.
- R4: The period is the base count shifted left by presc_i. The resistor code selects a base of RES_TICKS. presc_i is sampled only when a period starts, so a change during a period has no effect on that period.
- R5: A clear strobe in the first half of the period (before half the period's ticks have passed) raises mcu_rst_req_o on the next clock.
- R6: A clear strobe in the second half is accepted. No reset follows, and a new full period starts, again beginning with a closed half.
- R7: When the tick that completes the period arrives with no accepted clear, mcu_rst_req_o rises on the clock after that tick.
- R8: mcu_rst_req_o stays high for RST_TICKS ticks. If the mode is still Normal after release, a new period starts from zero with its closed half.
- R9: In Normal Request mode (mode_i = 1), a reset request is raised on the tick that completes NRQ_TICKS. Clear strobes have no effect in this mode.
- R10: In Reset and Sleep modes the watchdog does not count. On re-entry to Normal mode, a full fresh period starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Time-base tick enable, one clock wide |
| clr_i | input | 1 | Watchdog clear strobe, one clock wide |
| mode_i | input | 2 | Operating mode: 0 Reset, 1 Normal Request, 2 Normal, 3 Sleep |
| cfg_sense_i | input | 2 | Sensed pin configuration: 0 none, 1 resistor, 2 ground, 3 none |
| presc_i | input | PRESC_W | Prescaler shift code |
| mcu_rst_req_o | output | 1 | Processor reset request |
| wd_off_o | output | 1 | Watchdog-disabled status flag |
| tb_fault_o | output | 1 | Time-base fallback fault flag |

## Verification
The bench builds the block with RES_TICKS=8, DEF_TICKS=12, NRQ_TICKS=20 and RST_TICKS=3. At these values a period with prescaler code 0 lasts eight ticks, and its closed half ends after four. The edge of the window, the expiry tick, the shifted period of thirty-two ticks and the default period of twelve ticks can therefore each be checked one tick before and one tick at the boundary. The short reset hold and request timeout also make it possible to check, in a few dozen clocks, that the window restarts after release and that the request-mode timeout expires.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    typedef enum logic [1:0] {
        MODE_RESET  = 2'd0,
        MODE_NREQ   = 2'd1,
        MODE_NORMAL = 2'd2,
        MODE_SLEEP  = 2'd3
    } wdg_mode_e;

    typedef enum logic [1:0] {
        CFG_OPEN = 2'd0,
        CFG_RES  = 2'd1,
        CFG_GND  = 2'd2,
        CFG_BAD  = 2'd3
    } wdg_cfg_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_CLOSED = 3'd1,
        ST_OPEN   = 3'd2,
        ST_NREQ   = 3'd3,
        ST_RST    = 3'd4
    } wdg_state_e;

endpackage

// File: rtl/wdg_cfg_latch.sv
module wdg_cfg_latch #(
    parameter int RES_TICKS = 1500,
    parameter int DEF_TICKS = 1500,
    parameter int BW        = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode_i,
    input  logic [1:0]    sense_i,
    output logic          off_o,
    output logic          fault_o,
    output logic [BW-1:0] base_o
);
    import wdg_pkg::*;

    logic [1:0] sense_q;

    // Sense value follows the pin only while the device sits in Reset mode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sense_q <= CFG_RES;
        end else if (mode_i == MODE_RESET) begin
            sense_q <= sense_i;
        end
    end

    always_comb begin
        off_o   = (sense_q == CFG_GND);
        fault_o = (sense_q == CFG_OPEN) || (sense_q == CFG_BAD);
        base_o  = fault_o ? BW'(DEF_TICKS) : BW'(RES_TICKS);
    end

endmodule

// File: rtl/wdg_period.sv
module wdg_period #(
    parameter int BW = 11,
    parameter int PW = 2,
    parameter int CW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [BW-1:0] base_i,
    input  logic [PW-1:0] presc_i,
    output logic [CW-1:0] per_o,
    output logic [CW-1:0] half_o
);
    logic [CW-1:0] per_q;

    // Prescaled period is frozen at the start of each period
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_q <= CW'(2);
        end else if (load_i) begin
            per_q <= {{(CW-BW){1'b0}}, base_i} << presc_i;
        end
    end

    always_comb begin
        per_o  = per_q;
        half_o = per_q >> 1;
    end

endmodule

// File: rtl/wdg_fsm.sv
module wdg_fsm #(
    parameter int CW        = 14,
    parameter int NRQ_TICKS = 1500,
    parameter int RST_TICKS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_i,
    input  logic                clr_i,
    input  logic [1:0]          mode_i,
    input  logic                off_i,
    input  logic [CW-1:0]       per_i,
    input  logic [CW-1:0]       half_i,
    output logic                load_o,
    output logic                rst_req_o,
    output wdg_pkg::wdg_state_e st_o
);
    import wdg_pkg::*;

    localparam logic [CW-1:0] NRQ_LAST = CW'(NRQ_TICKS - 1);
    localparam logic [CW-1:0] RST_LAST = CW'(RST_TICKS - 1);

    wdg_state_e    st_q, st_d;
    logic [CW-1:0] cnt_q;
    logic          restart;
    logic          counting;

    function automatic wdg_state_e entry_st(input logic [1:0] m, input logic off);
        if (m == MODE_NORMAL && !off) return ST_CLOSED;
        else if (m == MODE_NREQ)      return ST_NREQ;
        else                          return ST_IDLE;
    endfunction

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                st_d = entry_st(mode_i, off_i);
            end
            ST_CLOSED: begin
                if (mode_i != MODE_NORMAL)                   st_d = entry_st(mode_i, off_i);
                else if (clr_i)                              st_d = ST_RST;
                else if (tick_i && cnt_q == half_i - CW'(1)) st_d = ST_OPEN;
            end
            ST_OPEN: begin
                if (mode_i != MODE_NORMAL)                   st_d = entry_st(mode_i, off_i);
                else if (clr_i)                              st_d = ST_CLOSED;
                else if (tick_i && cnt_q == per_i - CW'(1))  st_d = ST_RST;
            end
            ST_NREQ: begin
                if (mode_i != MODE_NREQ)                     st_d = entry_st(mode_i, off_i);
                else if (tick_i && cnt_q == NRQ_LAST)        st_d = ST_RST;
            end
            ST_RST: begin
                if (tick_i && cnt_q == RST_LAST)             st_d = entry_st(mode_i, off_i);
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Shared tick counter: cleared on every state change except the
    // closed-to-open handover, which keeps counting through the period
    always_comb begin
        restart  = (st_d != st_q) && !(st_q == ST_CLOSED && st_d == ST_OPEN);
        counting = (st_q != ST_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   cnt_q <= '0;
        else if (restart)             cnt_q <= '0;
        else if (tick_i && counting)  cnt_q <= cnt_q + CW'(1);
    end

    // Outputs
    always_comb begin
        load_o    = (st_d == ST_CLOSED) && (st_q != ST_CLOSED);
        rst_req_o = (st_q == ST_RST);
        st_o      = st_q;
    end

endmodule

// File: rtl/wdg_window_ctrl.sv
module wdg_window_ctrl #(
    parameter int RES_TICKS = 1500,
    parameter int DEF_TICKS = 1500,
    parameter int NRQ_TICKS = 1500,
    parameter int RST_TICKS = 16,
    parameter int PRESC_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    input  logic               clr_i,
    input  logic [1:0]         mode_i,
    input  logic [1:0]         cfg_sense_i,
    input  logic [PRESC_W-1:0] presc_i,
    output logic               mcu_rst_req_o,
    output logic               wd_off_o,
    output logic               tb_fault_o
);
    localparam int MAX_BASE = (RES_TICKS > DEF_TICKS) ? RES_TICKS : DEF_TICKS;
    localparam int BW       = $clog2(MAX_BASE + 1);
    localparam int MAX_SH   = (1 << PRESC_W) - 1;
    localparam int PCW      = BW + MAX_SH;
    localparam int NCW      = $clog2(NRQ_TICKS + 1);
    localparam int RCW      = $clog2(RST_TICKS + 1);
    localparam int CW01     = (PCW > NCW) ? PCW : NCW;
    localparam int CW       = (CW01 > RCW) ? CW01 : RCW;

    logic                base_off;
    logic                base_fault;
    logic [BW-1:0]       base_w;
    logic [CW-1:0]       per_w;
    logic [CW-1:0]       half_w;
    logic                load_w;
    wdg_pkg::wdg_state_e st_w;

    wdg_cfg_latch #(
        .RES_TICKS (RES_TICKS),
        .DEF_TICKS (DEF_TICKS),
        .BW        (BW)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_i  (mode_i),
        .sense_i (cfg_sense_i),
        .off_o   (base_off),
        .fault_o (base_fault),
        .base_o  (base_w)
    );

    wdg_period #(
        .BW (BW),
        .PW (PRESC_W),
        .CW (CW)
    ) u_per (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_w),
        .base_i  (base_w),
        .presc_i (presc_i),
        .per_o   (per_w),
        .half_o  (half_w)
    );

    wdg_fsm #(
        .CW        (CW),
        .NRQ_TICKS (NRQ_TICKS),
        .RST_TICKS (RST_TICKS)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .clr_i     (clr_i),
        .mode_i    (mode_i),
        .off_i     (base_off),
        .per_i     (per_w),
        .half_i    (half_w),
        .load_o    (load_w),
        .rst_req_o (mcu_rst_req_o),
        .st_o      (st_w)
    );

    assign wd_off_o   = base_off;
    assign tb_fault_o = base_fault;

endmodule

// File: rtl/wdg_window_chk.sv
module wdg_window_chk (
    input logic                clk,
    input logic                rst_n,
    input logic                tick_i,
    input logic                clr_i,
    input logic [1:0]          mode_i,
    input logic                rst_req,
    input logic                off,
    input logic                fault,
    input wdg_pkg::wdg_state_e st
);
    import wdg_pkg::*;

    // R1: flags only move while Reset mode is sampled
    p_cfg_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != MODE_RESET) |=> $stable({off, fault}));

    // R2: disabled watchdog stays quiet in Normal mode
    p_off_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (off && mode_i == MODE_NORMAL && st != ST_RST) |=> !rst_req);

    // R3: flags are mutually exclusive
    p_flag_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(off && fault));

    // R5: clear in closed window triggers reset
    p_closed_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CLOSED && mode_i == MODE_NORMAL && clr_i) |=> rst_req);

    // R8: request only drops after a tick
    p_rst_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req && !tick_i) |=> rst_req);

    // R9: clear ignored in Normal Request mode
    p_nreq_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_NREQ && mode_i == MODE_NREQ && clr_i && !tick_i) |=> !rst_req);

    // R10: no reset raised from Sleep outside the hold
    p_sleep_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_SLEEP && st != ST_RST) |=> !rst_req);

endmodule

bind wdg_window_ctrl wdg_window_chk chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick_i),
    .clr_i   (clr_i),
    .mode_i  (mode_i),
    .rst_req (mcu_rst_req_o),
    .off     (wd_off_o),
    .fault   (tb_fault_o),
    .st      (st_w)
);

// File: tb/wdg_window_ctrl_tb_top.sv
`timescale 1ns/1ps
module wdg_window_ctrl_tb_top;

    localparam int RES = 8;
    localparam int DEF = 12;
    localparam int NRQ = 20;
    localparam int RSTT = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       clr = 1'b0;
    logic [1:0] mode = 2'd0;
    logic [1:0] sense = 2'd1;
    logic [1:0] presc = 2'd0;
    logic       rst_req, off, fault;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    wdg_window_ctrl #(
        .RES_TICKS (RES),
        .DEF_TICKS (DEF),
        .NRQ_TICKS (NRQ),
        .RST_TICKS (RSTT),
        .PRESC_W   (2)
    ) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick_i        (tick),
        .clr_i         (clr),
        .mode_i        (mode),
        .cfg_sense_i   (sense),
        .presc_i       (presc),
        .mcu_rst_req_o (rst_req),
        .wd_off_o      (off),
        .tb_fault_o    (fault)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
    endtask

    task automatic clear();
        @(negedge clk) clr = 1'b1;
        @(negedge clk) clr = 1'b0;
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk) mode = m;
    endtask

    // Park in Reset mode, let any hold finish, capture sense code
    task automatic park(input logic [1:0] s, input logic [1:0] p);
        @(negedge clk);
        mode = 2'd0; sense = s; presc = p; clr = 1'b0; tick = 1'b0;
        ticks(RSTT + 2);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset_state();
        check("R1 reset req", rst_req, 1'b0);
        check("R1 reset off", off, 1'b0);
        check("R3 reset fault", fault, 1'b0);
    endtask

    task automatic t_cfg_flags();
        park(2'd2, 2'd0);
        check("R2 ground sets off", off, 1'b1);
        check("R3 ground no fault", fault, 1'b0);
        park(2'd0, 2'd0);
        check("R3 open sets fault", fault, 1'b1);
        park(2'd3, 2'd0);
        check("R3 code3 sets fault", fault, 1'b1);
        check("R3 code3 no off", off, 1'b0);
        park(2'd1, 2'd0);
        check("R1 resistor no fault", fault, 1'b0);
        set_mode(2'd2);
        @(negedge clk) sense = 2'd2;
        repeat (3) @(negedge clk);
        check("R1 sense ignored in Normal", off, 1'b0);
        set_mode(2'd3);
        @(negedge clk) sense = 2'd0;
        repeat (3) @(negedge clk);
        check("R1 sense ignored in Sleep", fault, 1'b0);
    endtask

    task automatic t_early_clear();
        park(2'd1, 2'd0);
        set_mode(2'd2);
        ticks(RES/2 - 1);
        check("R5 no req before clear", rst_req, 1'b0);
        clear();
        check("R5 closed clear raises req", rst_req, 1'b1);
    endtask

    task automatic t_open_clear();
        park(2'd1, 2'd0);
        set_mode(2'd2);
        ticks(RES/2);
        clear();
        check("R6 open clear accepted", rst_req, 1'b0);
        ticks(RES - 1);
        check("R6 new period not expired", rst_req, 1'b0);
        ticks(1);
        check("R7 expiry after restarted period", rst_req, 1'b1);
    endtask

    task automatic t_expiry_hold();
        park(2'd1, 2'd0);
        set_mode(2'd2);
        ticks(RES - 1);
        check("R7 no req one tick early", rst_req, 1'b0);
        ticks(1);
        check("R7 req on expiry", rst_req, 1'b1);
        repeat (4) @(negedge clk);
        check("R8 held without ticks", rst_req, 1'b1);
        ticks(RSTT - 1);
        check("R8 still held", rst_req, 1'b1);
        ticks(1);
        check("R8 released", rst_req, 1'b0);
        clear();
        check("R8 window restarts closed", rst_req, 1'b1);
    endtask

    task automatic t_presc();
        park(2'd1, 2'd2);
        set_mode(2'd2);
        ticks(4*RES/2 - 1);
        clear();
        check("R4 closed half scaled", rst_req, 1'b1);
        park(2'd1, 2'd2);
        set_mode(2'd2);
        ticks(2);
        @(negedge clk) presc = 2'd0;
        ticks(4*RES - 3);
        check("R4 mid-period presc ignored", rst_req, 1'b0);
        ticks(1);
        check("R4 scaled expiry", rst_req, 1'b1);
    endtask

    task automatic t_default();
        park(2'd0, 2'd0);
        set_mode(2'd2);
        ticks(DEF - 1);
        check("R3 default not expired", rst_req, 1'b0);
        ticks(1);
        check("R3 default expiry", rst_req, 1'b1);
    endtask

    task automatic t_off();
        park(2'd2, 2'd0);
        set_mode(2'd2);
        clear();
        check("R2 clear ignored when off", rst_req, 1'b0);
        ticks(5*RES);
        check("R2 no expiry when off", rst_req, 1'b0);
    endtask

    task automatic t_nreq();
        park(2'd1, 2'd0);
        set_mode(2'd1);
        ticks(2);
        clear();
        ticks(RES);
        clear();
        check("R9 clears ignored", rst_req, 1'b0);
        ticks(NRQ - RES - 3);
        check("R9 one tick early", rst_req, 1'b0);
        ticks(1);
        check("R9 timeout req", rst_req, 1'b1);
    endtask

    task automatic t_leave();
        park(2'd1, 2'd0);
        set_mode(2'd2);
        ticks(RES - 2);
        set_mode(2'd3);
        ticks(3*RES);
        check("R10 Sleep does not count", rst_req, 1'b0);
        set_mode(2'd2);
        ticks(RES - 1);
        check("R10 fresh period", rst_req, 1'b0);
        ticks(1);
        check("R10 expiry after re-entry", rst_req, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_cfg_flags();
        t_early_clear();
        t_open_clear();
        t_expiry_hold();
        t_presc();
        t_default();
        t_off();
        t_nreq();
        t_leave();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule